// File: doc/BRIEF.md
# Two-key watchdog timer

This block is a watchdog with a 32-bit register write and read port. Once enabled it counts clock cycles up to a power-of-two limit set by a 5-bit delay code. Firmware restarts the count by writing a first key word to one slot and then a second key word to another slot. If the count reaches its limit, if a key slot gets a wrong word, or if software asks for a reset, the block sends a one-cycle reset request to the system reset generator. The bus and the counter run on one clock.

A small cause register sits in its own power-on reset domain, so it survives the reset the watchdog asks for. Software reads it to learn why the last reset happened. Firmware can clear the enable bit, but the watchdog keeps running until the next full key sequence. After any request it raised, the block returns to the disabled state with delay code 0.

Top module: `magic_wdog`

## Requirements
- R1: Writes and reads decode word-aligned byte offsets: 0x0 is the soft-reset slot, 0x4 the configuration word, 0x8 the first key slot and 0xC the second key slot. In the configuration word, bit 31 is the enable and bits [4:0] are the delay code. Reading 0x4 returns exactly those fields, with every other bit 0.
- R2: While running, the block raises the reset request 2^(delay+1) clock cycles after the edge that started the count or last cleared it. It then records cause code 1.
- R3: A keepalive is 0xABCD1234 written to offset 0x8 followed by 0x4321DCBA written to offset 0xC. It clears the count to zero.
- R4: While running, a wrong word in either key slot, or a second-slot write without a correct first word before it, raises the request at once and records cause code 2. While stopped, the same writes raise no request and leave the cause unchanged.
- R5: Clearing the enable bit while running does not stop the count, and it does not clear it. The watchdog stops only at the next valid keepalive.
- R6: Writing a word with bit 0 set to offset 0x0 raises the request on the next edge and records cause code 3. A write there with bit 0 clear has no effect.
- R7: Reading offset 0x8 returns the cause in bits [2:0]. The power-on reset input sets it to 0, and a pulse on the user reset input sets it to 4. The system reset input leaves it unchanged.
- R8: The request is high for exactly one cycle. From that cycle on, the block is stopped, with enable 0 and delay code 0.
- R9: A delay code written while running takes effect only from the next clear of the count. Writing the enable again while already running does not restart the count.
- R10: When events coincide, the recorded cause follows the priority user > soft > bad key > timeout. A valid keepalive captured on the expiry edge prevents the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for bus and counter |
| rst_n | input | 1 | Active-low system reset, asynchronous |
| por_n | input | 1 | Active-low power-on reset for the cause register |
| user_rst_i | input | 1 | Pulse marking a user-initiated reset |
| bus_we | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| sys_rst_req | output | 1 | One-cycle reset request |

## Verification
The hardest cases to reach are the ones where a key sequence lands on the very edge where the count expires. Both outcomes meet on that edge: a good second key must win over the timeout, and a bad one must record code 2 rather than 1. The stimulus places the second-key write by counting idle cycles from the enable write. It then checks how many cycles pass before the next request. Randomised delays and keepalive points move the keepalive across the whole legal window.

// File: rtl/magic_wdog_pkg.sv
package magic_wdog_pkg;

    localparam int CAUSE_W = 3;

    localparam logic [31:0] KEY_FIRST  = 32'hABCD1234;
    localparam logic [31:0] KEY_SECOND = 32'h4321DCBA;

    // register slots, selected by address bits [3:2]
    localparam logic [1:0] SLOT_SRST = 2'd0;
    localparam logic [1:0] SLOT_CFG  = 2'd1;
    localparam logic [1:0] SLOT_KEY1 = 2'd2;
    localparam logic [1:0] SLOT_KEY2 = 2'd3;

    // last-reset cause codes
    localparam logic [CAUSE_W-1:0] CAUSE_POWER  = 3'd0;
    localparam logic [CAUSE_W-1:0] CAUSE_EXPIRE = 3'd1;
    localparam logic [CAUSE_W-1:0] CAUSE_BADKEY = 3'd2;
    localparam logic [CAUSE_W-1:0] CAUSE_SOFT   = 3'd3;
    localparam logic [CAUSE_W-1:0] CAUSE_USER   = 3'd4;

    typedef struct packed {
        logic srst;
        logic cfg;
        logic key1;
        logic key2;
    } wr_strobe_t;

endpackage

// File: rtl/magic_wdog_decode.sv
module magic_wdog_decode
    import magic_wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int DLY_W  = 5,
    parameter int EN_BIT = 31
) (
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic                 cfg_en_i,
    input  logic [DLY_W-1:0]     cfg_dly_i,
    input  logic [CAUSE_W-1:0]   cause_i,
    output wr_strobe_t           strobe_o,
    output logic [DATA_W-1:0]    rdata_o
);

    logic       aligned;
    logic [1:0] slot;

    always_comb begin
        aligned = (addr_i[1:0] == 2'b00);
        slot    = addr_i[3:2];
        if (ADDR_W > 4) begin
            aligned = aligned && (addr_i >> 4) == '0;
        end
    end

    always_comb begin
        strobe_o      = '0;
        strobe_o.srst = we_i && aligned && slot == SLOT_SRST;
        strobe_o.cfg  = we_i && aligned && slot == SLOT_CFG;
        strobe_o.key1 = we_i && aligned && slot == SLOT_KEY1;
        strobe_o.key2 = we_i && aligned && slot == SLOT_KEY2;
    end

    always_comb begin
        rdata_o = '0;
        if (aligned) begin
            case (slot)
                SLOT_CFG: begin
                    rdata_o[EN_BIT]    = cfg_en_i;
                    rdata_o[DLY_W-1:0] = cfg_dly_i;
                end
                SLOT_KEY1: rdata_o[CAUSE_W-1:0] = cause_i;
                default:   rdata_o = '0;
            endcase
        end
    end

    always_comb begin
        assert ($onehot0(strobe_o)) else $error("AST_ONE_SLOT failed"); // R1
    end

endmodule

// File: rtl/magic_wdog_keyseq.sv
module magic_wdog_keyseq
    import magic_wdog_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_i,
    input  logic              key1_wr_i,
    input  logic              key2_wr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              good_o,
    output logic              bad_o
);

    typedef struct packed {
        logic armed;
    } seq_t;

    seq_t s_q, s_d;
    logic first_ok, second_ok;

    always_comb begin
        first_ok  = (wdata_i == DATA_W'(KEY_FIRST));
        second_ok = (wdata_i == DATA_W'(KEY_SECOND));
        good_o    = key2_wr_i && s_q.armed && second_ok;
        bad_o     = (key1_wr_i && !first_ok) || (key2_wr_i && !good_o);

        s_d = s_q;
        if (key1_wr_i) begin
            s_d.armed = first_ok;
        end
        if (key2_wr_i) begin
            s_d.armed = 1'b0;
        end
        if (wipe_i) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    AST_KEY2_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
        key2_wr_i |=> !s_q.armed) else $error("AST_KEY2_DISARMS"); // R3
    AST_GOOD_NEEDS_KEY1: assert property (@(posedge clk) disable iff (!rst_n)
        (key1_wr_i && !first_ok) |=> !good_o) else $error("AST_GOOD_NEEDS_KEY1"); // R4

endmodule

// File: rtl/magic_wdog_timer.sv
module magic_wdog_timer #(
    parameter int DLY_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wipe_i,
    input  logic              cfg_wr_i,
    input  logic              cfg_en_i,
    input  logic [DLY_W-1:0]  cfg_dly_i,
    input  logic              ka_i,
    output logic              en_o,
    output logic [DLY_W-1:0]  dly_o,
    output logic              run_o,
    output logic              expire_o
);

    localparam int CNT_W = 2 ** DLY_W;

    typedef struct packed {
        logic             en;
        logic [DLY_W-1:0] dly;
        logic             run;
        logic [DLY_W-1:0] act_dly;
        logic [CNT_W-1:0] count;
    } tmr_t;

    tmr_t s_q, s_d;

    function automatic logic [CNT_W-1:0] span_mask(input logic [DLY_W-1:0] d);
        return {CNT_W{1'b1}} >> (CNT_W - 1 - int'(d));
    endfunction

    always_comb begin
        s_d = s_q;
        if (s_q.run) begin
            s_d.count = s_q.count + 1'b1;
        end
        if (cfg_wr_i) begin
            s_d.en  = cfg_en_i;
            s_d.dly = cfg_dly_i;
            if (cfg_en_i && !s_q.run) begin
                s_d.run     = 1'b1;
                s_d.count   = '0;
                s_d.act_dly = cfg_dly_i;
            end
        end
        if (ka_i) begin
            s_d.count   = '0;
            s_d.act_dly = s_d.dly;
            s_d.run     = s_q.run && s_d.en;
        end
        if (wipe_i) begin
            s_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    always_comb begin
        en_o     = s_q.en;
        dly_o    = s_q.dly;
        run_o    = s_q.run;
        expire_o = s_q.run && (s_q.count == span_mask(s_q.act_dly));
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> s_q.count <= span_mask(s_q.act_dly)) else $error("AST_CNT_BOUND"); // R2
    AST_STOP_AFTER_KA: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(s_q.run) |-> $past(ka_i || wipe_i)) else $error("AST_STOP_AFTER_KA"); // R5
    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.run |-> s_q.count == '0) else $error("AST_IDLE_CLEAR"); // R8
    AST_LIMIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.run && !ka_i && !wipe_i) |=> $stable(s_q.act_dly)) else $error("AST_LIMIT_HELD"); // R9

endmodule

// File: rtl/magic_wdog_cause.sv
module magic_wdog_cause
    import magic_wdog_pkg::*;
(
    input  logic               clk,
    input  logic               por_n,
    input  logic               user_i,
    input  logic               soft_i,
    input  logic               bad_i,
    input  logic               tmo_i,
    output logic [CAUSE_W-1:0] cause_o
);

    typedef struct packed {
        logic [CAUSE_W-1:0] code;
    } cause_t;

    cause_t s_q, s_d;

    always_comb begin
        s_d = s_q;
        if (user_i) begin
            s_d.code = CAUSE_USER;
        end else if (soft_i) begin
            s_d.code = CAUSE_SOFT;
        end else if (bad_i) begin
            s_d.code = CAUSE_BADKEY;
        end else if (tmo_i) begin
            s_d.code = CAUSE_EXPIRE;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            s_q <= '{code: CAUSE_POWER};
        end else begin
            s_q <= s_d;
        end
    end

    assign cause_o = s_q.code;

    AST_CAUSE_RANGE: assert property (@(posedge clk) disable iff (!por_n)
        s_q.code <= CAUSE_USER) else $error("AST_CAUSE_RANGE"); // R7
    AST_USER_WINS: assert property (@(posedge clk) disable iff (!por_n)
        user_i |=> s_q.code == CAUSE_USER) else $error("AST_USER_WINS"); // R10
    AST_CAUSE_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        !(user_i || soft_i || bad_i || tmo_i) |=> $stable(s_q.code)) else $error("AST_CAUSE_QUIET"); // R7

endmodule

// File: rtl/magic_wdog.sv
module magic_wdog
    import magic_wdog_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4,
    parameter int DLY_W  = 5,
    parameter int EN_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              user_rst_i,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              sys_rst_req
);

    typedef struct packed {
        logic req;
    } top_t;

    top_t               s_q, s_d;
    wr_strobe_t         strobe;
    logic               ka_good, ka_bad;
    logic               cfg_en, run, expire;
    logic [DLY_W-1:0]   cfg_dly;
    logic [CAUSE_W-1:0] cause;
    logic               soft_ev, bad_ev, tmo_ev, wipe;

    magic_wdog_decode #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DLY_W  (DLY_W),
        .EN_BIT (EN_BIT)
    ) u_decode (
        .we_i      (bus_we),
        .addr_i    (bus_addr),
        .cfg_en_i  (cfg_en),
        .cfg_dly_i (cfg_dly),
        .cause_i   (cause),
        .strobe_o  (strobe),
        .rdata_o   (bus_rdata)
    );

    magic_wdog_keyseq #(
        .DATA_W (DATA_W)
    ) u_keyseq (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe_i    (wipe),
        .key1_wr_i (strobe.key1),
        .key2_wr_i (strobe.key2),
        .wdata_i   (bus_wdata),
        .good_o    (ka_good),
        .bad_o     (ka_bad)
    );

    magic_wdog_timer #(
        .DLY_W (DLY_W)
    ) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .wipe_i    (wipe),
        .cfg_wr_i  (strobe.cfg),
        .cfg_en_i  (bus_wdata[EN_BIT]),
        .cfg_dly_i (bus_wdata[DLY_W-1:0]),
        .ka_i      (ka_good),
        .en_o      (cfg_en),
        .dly_o     (cfg_dly),
        .run_o     (run),
        .expire_o  (expire)
    );

    magic_wdog_cause u_cause (
        .clk     (clk),
        .por_n   (por_n),
        .user_i  (user_rst_i),
        .soft_i  (soft_ev),
        .bad_i   (bad_ev),
        .tmo_i   (tmo_ev),
        .cause_o (cause)
    );

    always_comb begin
        soft_ev = strobe.srst && bus_wdata[0];
        bad_ev  = ka_bad && run;
        tmo_ev  = expire && !ka_good;
        wipe    = soft_ev || bad_ev || tmo_ev;
        s_d     = s_q;
        s_d.req = wipe;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign sys_rst_req = s_q.req;

    AST_SOFT_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        soft_ev |=> sys_rst_req) else $error("AST_SOFT_REQ"); // R6
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !soft_ev) |=> !sys_rst_req) else $error("AST_IDLE_QUIET"); // R4
    AST_WIPED: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst_req |-> (!run && !cfg_en && cfg_dly == '0)) else $error("AST_WIPED"); // R8
    AST_KA_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (ka_good && !bus_wdata[0]) |=> !sys_rst_req) else $error("AST_KA_BEATS_EXPIRY"); // R10

endmodule

// File: tb/sim_magic_wdog.sv
module sim_magic_wdog;

    localparam logic [31:0] K1 = 32'hABCD1234;
    localparam logic [31:0] K2 = 32'h4321DCBA;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic        user_rst_i = 1'b0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sys_rst_req;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    magic_wdog u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .por_n      (por_n),
        .user_rst_i (user_rst_i),
        .bus_we     (bus_we),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .sys_rst_req(sys_rst_req)
    );

    function automatic int exp_period(input int d);
        return 1 << (d + 1);
    endfunction

    function automatic logic [31:0] exp_cfg(input logic en, input int d);
        return {en, 26'd0, 5'(d)};
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wait_req(input int max, output int n);
        n = 0;
        while (!sys_rst_req && n < max) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic keepalive();
        wr(4'h8, K1);
        wr(4'hC, K2);
    endtask

    initial begin
        #(5.0 * 150000);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        int n;
        void'($urandom(32'd4711));
        idle(2);
        por_n = 1'b1; rst_n = 1'b1;
        idle(1);

        // R1 / R7 reset state
        rd(4'h4, v); chk("R1 cfg after reset", v, 32'h0);
        rd(4'h8, v); chk("R7 cause after power-on", v, 32'h0);
        chk("R8 no request after reset", {31'd0, sys_rst_req}, 32'h0);

        // R1 field readback, other bits dropped, no start
        wr(4'h4, 32'h7FFF_FFE9);
        rd(4'h4, v); chk("R1 cfg readback", v, exp_cfg(1'b0, 9));
        rd(4'hC, v); chk("R1 slot 0xC reads zero", v, 32'h0);
        wait_req(40, n); chk("R1 disabled write starts nothing", n, 40);

        // R2 shortest timeout, R8 pulse and wipe
        wr(4'h4, exp_cfg(1'b1, 0));
        wait_req(100, n); chk("R2 timeout delay 0", n, exp_period(0));
        rd(4'h8, v); chk("R2 cause timeout", v, 32'd1);
        @(negedge clk); chk("R8 one-cycle pulse", {31'd0, sys_rst_req}, 32'h0);
        rd(4'h4, v); chk("R8 cfg wiped", v, 32'h0);

        // R2 / R3 random delays and keepalive points
        for (int it = 0; it < 8; it++) begin
            int d, w;
            d = 2 + int'($urandom % 4);
            w = int'($urandom % (exp_period(d) - 2));
            wr(4'h4, exp_cfg(1'b1, d));
            idle(w);
            keepalive();
            wait_req(200, n); chk("R3 keepalive restarts count", n, exp_period(d));
            rd(4'h8, v); chk("R2 cause after random run", v, 32'd1);
            idle(1);
        end

        // R4 bad key while running, random flavour
        for (int it = 0; it < 4; it++) begin
            logic [31:0] bad;
            bad = $urandom;
            if (bad == K1 || bad == K2) bad = bad ^ 32'h1;
            wr(4'h4, exp_cfg(1'b1, 4));
            idle(3);
            case (it % 3)
                0: wr(4'h8, bad);
                1: begin wr(4'h8, K1); wr(4'hC, bad); end
                default: wr(4'hC, K2);
            endcase
            chk("R4 bad key raises request", {31'd0, sys_rst_req}, 32'h1);
            rd(4'h8, v); chk("R4 cause bad key", v, 32'd2);
            idle(1);
        end

        // R4 bad key while stopped: ignored
        wr(4'h8, 32'h1234_5678);
        wr(4'hC, K2);
        wait_req(20, n); chk("R4 stopped bad key no request", n, 20);
        rd(4'h8, v); chk("R4 stopped cause unchanged", v, 32'd2);

        // R5 disable without keepalive keeps counting
        wr(4'h4, exp_cfg(1'b1, 3));
        wr(4'h4, exp_cfg(1'b0, 3));
        wait_req(100, n); chk("R5 disable alone does not stop", n, exp_period(3) - 1);
        idle(1);
        // R5 disable then keepalive stops it
        wr(4'h4, exp_cfg(1'b1, 2));
        wr(4'h4, exp_cfg(1'b0, 2));
        keepalive();
        wait_req(60, n); chk("R5 stopped after keepalive", n, 60);
        rd(4'h4, v); chk("R5 cfg shows disabled", v, exp_cfg(1'b0, 2));

        // R6 soft reset
        wr(4'h0, 32'hFFFF_FFFE);
        wait_req(10, n); chk("R6 bit0 clear ignored", n, 10);
        wr(4'h0, 32'h1);
        chk("R6 soft reset request", {31'd0, sys_rst_req}, 32'h1);
        rd(4'h8, v); chk("R6 cause soft", v, 32'd3);
        idle(1);

        // R7 cause survives system reset
        rst_n = 1'b0; idle(1); rst_n = 1'b1; idle(1);
        rd(4'h8, v); chk("R7 cause survives rst_n", v, 32'd3);
        user_rst_i = 1'b1; @(negedge clk); user_rst_i = 1'b0;
        rd(4'h8, v); chk("R7 user reset code", v, 32'd4);
        por_n = 1'b0; idle(1); por_n = 1'b1; idle(1);
        rd(4'h8, v); chk("R7 power-on code", v, 32'd0);

        // R9 delay change while running, and re-enable no restart
        wr(4'h4, exp_cfg(1'b1, 2));
        wr(4'h4, exp_cfg(1'b1, 5));
        wait_req(200, n); chk("R9 old delay still in force", n, exp_period(2) - 1);
        idle(1);
        wr(4'h4, exp_cfg(1'b1, 2));
        wr(4'h4, exp_cfg(1'b1, 4));
        keepalive();
        wait_req(200, n); chk("R9 new delay after clear", n, exp_period(4));
        idle(1);

        // R10 keepalive on the expiry edge wins
        wr(4'h4, exp_cfg(1'b1, 2));
        idle(6);
        keepalive();
        wait_req(100, n); chk("R10 keepalive beats expiry", n, exp_period(2));
        rd(4'h8, v); chk("R10 cause after late keepalive", v, 32'd1);
        idle(1);
        // R10 bad key on the expiry edge
        wr(4'h4, exp_cfg(1'b1, 2));
        idle(6);
        wr(4'h8, K1);
        wr(4'hC, 32'h0);
        chk("R10 request on bad key at expiry", {31'd0, sys_rst_req}, 32'h1);
        rd(4'h8, v); chk("R10 bad key beats timeout", v, 32'd2);
        idle(1);
        // R10 user beats soft
        user_rst_i = 1'b1;
        wr(4'h0, 32'h1);
        user_rst_i = 1'b0;
        chk("R10 soft still requests", {31'd0, sys_rst_req}, 32'h1);
        rd(4'h8, v); chk("R10 user beats soft", v, 32'd4);
        idle(2);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule